// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block works out which display is attached by exercising three open-drain identification lines, called A, B and C here. A single-cycle start request from the host launches a scan. The scan first drives every line high for a short settle time and then lets all of them float for a longer settle time. It then records the level of all three lines. Next it pulls each line low in turn, one after another, and records the two lines it is not pulling. The recorded bits are gathered into an 11-bit sense code. The host reads the code once the done flag rises. Turning that code into a display mode is left to the host.

The pads are controlled through two 3-bit outputs. One gives the value each line is driven to. The other disables the driver of each line; a disabled line is left to its external pull-up. The short settle time comes from an input and is counted in clock cycles. The long settle time is always ten times the short one. The line inputs pass through a two-stage synchronizer before they are recorded.

Top module: `mon_sense_seq`

## Requirements
- R1: While reset is held and just after it is released, busy_o=0, done_o=0, code_o=0, drv_dis_o=3'b111 and drv_val_o=3'b111. In every 3-bit field, A is bit 2, B is bit 1 and C is bit 0.
- R2: A start_i pulse while idle makes busy_o high from the next cycle. The first phase drives all lines high (drv_dis_o=000, drv_val_o=111). The second phase floats all lines (drv_dis_o=111, drv_val_o=111).
- R3: Let S be settle_i. The first phase lasts S cycles. The float phase and each of the three pull phases last 10*S cycles. busy_o is therefore high for exactly 41*S cycles.
- R4: The three pull phases come in the order A, B, C. Each drives exactly one line low: A uses drv_dis_o=drv_val_o=011, B uses 101 and C uses 110. A line whose driver is disabled always has a drive value of 1.
- R5: The levels recorded at the end of the float phase go to code bit 10 (A), bit 9 (B) and bit 8 (C).
- R6: While A is pulled low, B is recorded into code bit 5 and C into code bit 4.
- R7: While B is pulled low, A is recorded into code bit 3 and C into code bit 2.
- R8: While C is pulled low, A is recorded into code bit 1 and B into code bit 0.
- R9: Code bits 7 and 6 always read 0.
- R10: A start_i pulse while busy_o is high is ignored. The scan length and the final code are unchanged.
- R11: done_o rises when the scan ends and stays high until the next accepted start, which clears it and clears the code. done_o and busy_o are never high together.
- R12: settle_i=0 is treated as 1, so the scan lasts 41 cycles.
- R13: Whenever the block is idle, all drivers are disabled (drv_dis_o=111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle scan request |
| settle_i | input | SETTLE_W | Short settle time in cycles (0 acts as 1) |
| sense_i | input | 3 | Line levels as seen at the pads (A=2, B=1, C=0) |
| drv_val_o | output | 3 | Drive value for each line |
| drv_dis_o | output | 3 | Driver disable for each line, 1 = released |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished; code valid |
| code_o | output | 11 | Packed sense code |

## Verification
The assertions rely on three things about the inputs. start_i is a single-cycle pulse. The host issues no start during the two cycles after reset release, while the internal reset is still held. settle_i is held steady for the whole scan. The checks on code stability and on the busy/done handshake depend on these. The bench drives start_i and settle_i only on falling edges and keeps settle_i fixed during each scan. It waits several cycles after reset before the first request. It models the display as a set of grounded lines and line-to-line straps, which derive the pad levels from the block's own drive outputs. The settle values it uses are long enough to cover the synchronizer delay.

// File: rtl/mss_pkg.sv
package mss_pkg;
  localparam int LINES    = 3;
  localparam int CODE_W   = 11;
  localparam int LONG_MUL = 10;
  localparam int LN_A     = 2;
  localparam int LN_B     = 1;
  localparam int LN_C     = 0;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_HIGH   = 3'd1,
    PH_FLOAT  = 3'd2,
    PH_PULL_A = 3'd3,
    PH_PULL_B = 3'd4,
    PH_PULL_C = 3'd5
  } phase_e;
endpackage

// File: rtl/mss_sync.sv
module mss_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mss_timer.sv
module mss_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = len_i - CNT_W'(1);
    else        cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/mss_ctrl.sv
module mss_ctrl
  import mss_pkg::*;
#(
  parameter int SETTLE_W = 12,
  localparam int LEN_W   = SETTLE_W + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                last_i,
  output logic                load_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                accept_o,
  output logic                samp_o,
  output phase_e              phase_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [LINES-1:0]    drv_val_o,
  output logic [LINES-1:0]    drv_dis_o
);
  phase_e           state_q, state_d;
  logic             done_q, done_d;
  logic [LEN_W-1:0] short_len;
  logic [LEN_W-1:0] long_len;

  always_comb begin
    short_len = (settle_i == '0) ? LEN_W'(1) : LEN_W'(settle_i);
    long_len  = LEN_W'(short_len * LEN_W'(LONG_MUL));
  end

  always_comb begin
    state_d  = state_q;
    done_d   = done_q;
    load_o   = 1'b0;
    len_o    = long_len;
    samp_o   = 1'b0;
    accept_o = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = PH_HIGH;
          load_o   = 1'b1;
          len_o    = short_len;
          done_d   = 1'b0;
        end
      end
      PH_HIGH: begin
        if (last_i) begin
          state_d = PH_FLOAT;
          load_o  = 1'b1;
        end
      end
      PH_FLOAT: begin
        if (last_i) begin
          samp_o  = 1'b1;
          state_d = PH_PULL_A;
          load_o  = 1'b1;
        end
      end
      PH_PULL_A: begin
        if (last_i) begin
          samp_o  = 1'b1;
          state_d = PH_PULL_B;
          load_o  = 1'b1;
        end
      end
      PH_PULL_B: begin
        if (last_i) begin
          samp_o  = 1'b1;
          state_d = PH_PULL_C;
          load_o  = 1'b1;
        end
      end
      PH_PULL_C: begin
        if (last_i) begin
          samp_o  = 1'b1;
          state_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    drv_dis_o = '1;
    drv_val_o = '1;
    case (state_q)
      PH_HIGH:   drv_dis_o = '0;
      PH_PULL_A: begin drv_dis_o[LN_A] = 1'b0; drv_val_o[LN_A] = 1'b0; end
      PH_PULL_B: begin drv_dis_o[LN_B] = 1'b0; drv_val_o[LN_B] = 1'b0; end
      PH_PULL_C: begin drv_dis_o[LN_C] = 1'b0; drv_val_o[LN_C] = 1'b0; end
      default: ;
    endcase
  end

  assign phase_o = state_q;
  assign busy_o  = (state_q != PH_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/mon_sense_seq.sv
module mon_sense_seq
  import mss_pkg::*;
#(
  parameter int SETTLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [2:0]          sense_i,
  output logic [2:0]          drv_val_o,
  output logic [2:0]          drv_dis_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [10:0]         code_o
);
  localparam int LEN_W = SETTLE_W + 4;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [LINES-1:0]  lvl_sync;
  logic              tmr_load;
  logic [LEN_W-1:0]  tmr_len;
  logic              tmr_last;
  logic              accept;
  logic              samp;
  phase_e            phase;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  mss_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (sense_i),
    .q_o   (lvl_sync)
  );

  mss_timer #(.CNT_W(LEN_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .last_o (tmr_last)
  );

  mss_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .settle_i  (settle_i),
    .last_i    (tmr_last),
    .load_o    (tmr_load),
    .len_o     (tmr_len),
    .accept_o  (accept),
    .samp_o    (samp),
    .phase_o   (phase),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .drv_val_o (drv_val_o),
    .drv_dis_o (drv_dis_o)
  );

  always_comb begin
    code_en = accept || samp;
    code_d  = code_q;
    if (accept) begin
      code_d = '0;
    end else begin
      case (phase)
        PH_FLOAT:  code_d[10:8] = {lvl_sync[LN_A], lvl_sync[LN_B], lvl_sync[LN_C]};
        PH_PULL_A: code_d[5:4]  = {lvl_sync[LN_B], lvl_sync[LN_C]};
        PH_PULL_B: code_d[3:2]  = {lvl_sync[LN_A], lvl_sync[LN_C]};
        PH_PULL_C: code_d[1:0]  = {lvl_sync[LN_A], lvl_sync[LN_B]};
        default: ;
      endcase
    end
    code_d[7:6] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/mss_chk.sv
module mss_chk #(
  parameter int SETTLE_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [SETTLE_W-1:0] settle_i,
  input logic [2:0]          sense_i,
  input logic [2:0]          drv_val_o,
  input logic [2:0]          drv_dis_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [10:0]         code_o
);
  p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_released_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_dis_o & ~drv_val_o) == 3'b000);

  p_one_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~drv_val_o) <= 1);

  p_idle_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (drv_dis_o == 3'b111));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_o[7:6] == 2'b00);

  p_code_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(code_o));
endmodule

bind mon_sense_seq mss_chk #(.SETTLE_W(SETTLE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .settle_i  (settle_i),
  .sense_i   (sense_i),
  .drv_val_o (drv_val_o),
  .drv_dis_o (drv_dis_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .code_o    (code_o)
);

// File: tb/mon_sense_seq_tb.sv
module mon_sense_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int NV = 6;
  // fields: gnd[28:26] (A,B,C), straps[25:23] (AB,AC,BC), settle[22:11], expected code[10:0]
  localparam logic [28:0] VEC [NV] = '{
    {3'b000, 3'b000, 12'd4, 11'h73F},
    {3'b111, 3'b000, 12'd5, 11'h000},
    {3'b000, 3'b100, 12'd4, 11'h717},
    {3'b001, 3'b000, 12'd6, 11'h62B},
    {3'b100, 3'b001, 12'd4, 11'h330},
    {3'b000, 3'b010, 12'd7, 11'h72D}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [2:0]    gnd = 3'b000;
  logic [2:0]    strap = 3'b000;
  logic [2:0]    sense, low_src, dval, ddis;
  logic          busy, done;
  logic [10:0]   code;
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;
  bit            finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign low_src  = gnd | (~ddis & ~dval);
  assign sense[2] = !(low_src[2] | (strap[2] & low_src[1]) | (strap[1] & low_src[0]));
  assign sense[1] = !(low_src[1] | (strap[2] & low_src[2]) | (strap[0] & low_src[0]));
  assign sense[0] = !(low_src[0] | (strap[1] & low_src[2]) | (strap[0] & low_src[1]));

  mon_sense_seq #(.SETTLE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_i(settle),
    .sense_i(sense), .drv_val_o(dval), .drv_dis_o(ddis),
    .busy_o(busy), .done_o(done), .code_o(code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  // Runs one scan and counts busy cycles and pad mismatches; a second start is pulsed at cycle extra_at.
  task automatic run_scan(input int st, input int extra_at, output int nbusy, output int pad_err);
    int eff;
    int ph;
    logic [2:0] ed, ev;
    eff = (st == 0) ? 1 : st;
    pad_err = 0;
    nbusy = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (busy) begin
      ph = (nbusy < eff) ? 1 : 2 + (nbusy - eff) / (10 * eff);
      case (ph)
        1:       begin ed = 3'b000; ev = 3'b111; end
        2:       begin ed = 3'b111; ev = 3'b111; end
        3:       begin ed = 3'b011; ev = 3'b011; end
        4:       begin ed = 3'b101; ev = 3'b101; end
        default: begin ed = 3'b110; ev = 3'b110; end
      endcase
      if (ddis !== ed || dval !== ev) pad_err++;
      start = (nbusy == extra_at);
      nbusy++;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    int nb, pe, eff;
    logic [10:0] saved;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk(!busy && !done && code == 0, "R1 reset held", {busy, done, code}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ddis == 3'b111 && dval == 3'b111 && code == 0 && !busy && !done,
        "R1 after release", {ddis, dval, code}, {3'b111, 3'b111, 11'h0});

    for (int i = 0; i < NV; i++) begin
      gnd    = VEC[i][28:26];
      strap  = VEC[i][25:23];
      settle = VEC[i][22:11];
      eff    = int'(VEC[i][22:11]);
      run_scan(eff, -1, nb, pe);
      chk(nb == 41 * eff, "R3 busy length", nb, 41 * eff);
      chk(pe == 0, "R2 R4 pad sequence mismatches", pe, 0);
      chk(code == VEC[i][10:0], "R5 R6 R7 R8 code", code, VEC[i][10:0]);
      chk(code[7:6] == 2'b00, "R9 unused bits", code[7:6], 0);
      chk(done && !busy, "R11 done at end", {done, busy}, 2'b10);
      chk(ddis == 3'b111, "R13 released when idle", ddis, 3'b111);
    end

    // R10: extra start during the scan is ignored (straps AB, settle 5)
    gnd = 3'b000; strap = 3'b100; settle = 12'd5;
    run_scan(5, 60, nb, pe);
    chk(nb == 205, "R10 length with start while busy", nb, 205);
    chk(code == 11'h717, "R10 code with start while busy", code, 11'h717);

    // R11: done and code hold while idle
    saved = code;
    repeat (20) @(negedge clk);
    chk(done && code == saved, "R11 done held", {done, code}, {1'b1, saved});

    // R11: an accepted start clears done and code
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!done && busy && code == 0, "R11 start clears done", {done, busy, code}, 2'b01 << 11);
    while (busy) @(negedge clk);

    // R12: settle of zero acts as one
    gnd = 3'b000; strap = 3'b000; settle = '0;
    run_scan(0, -1, nb, pe);
    chk(nb == 41, "R12 zero settle length", nb, 41);
    chk(pe == 0, "R12 zero settle pads", pe, 0);

    summary();
  end
endmodule